// File: doc/BRIEF.md
# Read-First Multi-Port RAM with Delayed Write Commit

This block is a synchronous RAM with several write ports and several read ports, all on one clock edge. Every read port behaves read-first: a read sampled on the same edge as a write to the same word returns the word as it was before that write. A read on the following edge returns the new contents. The storage array itself does not order reads before writes. Each write request is instead held in a one-cycle pipeline register and committed to the array on the next edge. Each read port merges those held writes into the stored word on the way out, so the held writes are visible to it.

Each write port carries an address, a data word and one enable per lane. A lane is a contiguous group of `DATA_W / LANES` bits, and its single enable is stored in one delayed flop. That flop is widened back into a per-bit mask where the write is applied. Each read port has an enable and an address, and returns registered data one edge later. When its enable is low, the read port keeps its previous output. Write ports are ranked by index, and the higher index wins wherever two writes to one word in one cycle overlap. The array and the read forwarding both apply that ranking.

The array contents have no reset. Reset clears the delayed lane enables, so any request presented while reset is low is never committed. Reset also clears the read outputs.

Top module: `rfram_top`

## Requirements
- R1: A read enabled on an edge returns, after that edge, the word with every write issued on earlier edges applied, one cycle of latency.
- R2: A read and a write to the same address on the same edge: the read returns the contents from before that write.
- R3: While `rst_n` is low, write requests are discarded and never reach the array, and every `rd_data` slice is zero after a reset edge.
- R4: Write lane k covers data bits [k*DATA_W/LANES +: DATA_W/LANES]. Bits in lanes whose enable is low keep their old value.
- R5: A read on the edge right after a write to the same address returns the new data, before the array itself has been updated.
- R6: Two writes to one address on one edge: on lanes enabled by both, the higher-numbered write port's data is kept. Lanes enabled by only one port take that port's data. The rule is the same whether the word is read back on the next edge or later.
- R7: A read port whose enable is low on an edge keeps its `rd_data` slice unchanged.
- R8: Every read port has its own address and sees the same memory contents as every other read port.
- R9: A write request with all lane enables low changes no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock, rising edge for all ports |
| rst_n | input | 1 | Synchronous active-low reset of lane pipeline and read outputs |
| wr_addr | input | N_WR*ADDR_W | Write addresses, port p at [p*ADDR_W +: ADDR_W] |
| wr_data | input | N_WR*DATA_W | Write data, port p at [p*DATA_W +: DATA_W] |
| wr_lane | input | N_WR*LANES | Lane enables, port p at [p*LANES +: LANES] |
| rd_en | input | N_RD | Read enable per read port |
| rd_addr | input | N_RD*ADDR_W | Read addresses, port r at [r*ADDR_W +: ADDR_W] |
| rd_data | output | N_RD*DATA_W | Registered read data, port r at [r*DATA_W +: DATA_W] |

## Verification
The bench builds the RAM with a 16-bit word in two 8-bit lanes, two write ports, two read ports and only eight words. The small depth makes random traffic hit the same word again and again. It produces same-edge read/write collisions, back-to-back read-after-write through the forwarding path, and two write ports landing on one word with overlapping or disjoint lanes. Two lanes are enough to reach partial writes, merged writes and overlap priority. Two ports of each kind are enough to exercise the write ranking and independent read addresses.

// File: rtl/rfram_pkg.sv
package rfram_pkg;

    // Width of one write lane in bits.
    function automatic int lane_bits(input int data_w, input int lanes);
        return data_w / lanes;
    endfunction

endpackage

// File: rtl/rfram_wr_stage.sv
// One write port's pipeline stage: the request is held for one cycle
// before the array and the read bypass see it.
module rfram_wr_stage #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [LANES-1:0]  req_lane,
    output logic [ADDR_W-1:0] pnd_addr,
    output logic [DATA_W-1:0] pnd_data,
    output logic [LANES-1:0]  pnd_lane
);

    // Address and data need no defined start value.
    always_ff @(posedge clk) begin
        pnd_addr <= req_addr;
        pnd_data <= req_data;
    end

    // One flop per lane; cleared so nothing commits right after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pnd_lane <= '0;
        end else begin
            pnd_lane <= req_lane;
        end
    end

endmodule

// File: rtl/rfram_store.sv
// Storage array: commits the delayed writes, with a fixed port ranking,
// and offers one asynchronous read tap per read port.
module rfram_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int LANES  = 4,
    parameter int N_WR   = 2,
    parameter int N_RD   = 2
) (
    input  logic                     clk,
    input  logic [N_WR*ADDR_W-1:0]   cm_addr,
    input  logic [N_WR*DATA_W-1:0]   cm_data,
    input  logic [N_WR*LANES-1:0]    cm_lane,
    input  logic [N_RD*ADDR_W-1:0]   tap_addr,
    output logic [N_RD*DATA_W-1:0]   tap_word
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int LW    = rfram_pkg::lane_bits(DATA_W, LANES);

    logic [DATA_W-1:0] mem    [DEPTH];
    logic [ADDR_W-1:0] wa     [N_WR];
    logic [DATA_W-1:0] wd     [N_WR];
    logic [DATA_W-1:0] wm     [N_WR];
    logic              wany   [N_WR];
    logic [DATA_W-1:0] merged [N_WR];

    for (genvar p = 0; p < N_WR; p++) begin : g_unpack
        assign wa[p]   = cm_addr[p*ADDR_W +: ADDR_W];
        assign wd[p]   = cm_data[p*DATA_W +: DATA_W];
        assign wany[p] = |cm_lane[p*LANES +: LANES];
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign wm[p][l*LW +: LW] = {LW{cm_lane[p*LANES + l]}};
        end
    end

    // Each port's committed word folds in every lower-ranked port that
    // hits the same word, so the highest-ranked writer carries all lanes.
    always_comb begin
        for (int p = 0; p < N_WR; p++) begin
            merged[p] = mem[wa[p]];
            for (int q = 0; q < N_WR; q++) begin
                if (q <= p && wa[q] == wa[p]) begin
                    merged[p] = (merged[p] & ~wm[q]) | (wd[q] & wm[q]);
                end
            end
        end
    end

    // Later iterations override earlier ones: highest index wins.
    always_ff @(posedge clk) begin
        for (int p = 0; p < N_WR; p++) begin
            if (wany[p]) begin
                mem[wa[p]] <= merged[p];
            end
        end
    end

    for (genvar r = 0; r < N_RD; r++) begin : g_tap
        assign tap_word[r*DATA_W +: DATA_W] = mem[tap_addr[r*ADDR_W +: ADDR_W]];
    end

endmodule

// File: rtl/rfram_rd_port.sv
// One read port: stored word plus forwarding of every pending write,
// applied in rank order, into a registered output.
module rfram_rd_port #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int LANES  = 4,
    parameter int N_WR   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      stored,
    input  logic [N_WR*ADDR_W-1:0] pnd_addr,
    input  logic [N_WR*DATA_W-1:0] pnd_data,
    input  logic [N_WR*LANES-1:0]  pnd_lane,
    output logic [DATA_W-1:0]      data
);

    localparam int LW = rfram_pkg::lane_bits(DATA_W, LANES);

    logic [DATA_W-1:0] pmask [N_WR];
    logic [DATA_W-1:0] fwd;

    for (genvar p = 0; p < N_WR; p++) begin : g_mask
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign pmask[p][l*LW +: LW] = {LW{pnd_lane[p*LANES + l]}};
        end
    end

    always_comb begin
        fwd = stored;
        for (int p = 0; p < N_WR; p++) begin
            if (pnd_addr[p*ADDR_W +: ADDR_W] == addr) begin
                fwd = (fwd & ~pmask[p]) | (pnd_data[p*DATA_W +: DATA_W] & pmask[p]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (en) begin
            data <= fwd;
        end
    end

endmodule

// File: rtl/rfram_top.sv
module rfram_top #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int N_WR   = 2,
    parameter int N_RD   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_WR*ADDR_W-1:0] wr_addr,
    input  logic [N_WR*DATA_W-1:0] wr_data,
    input  logic [N_WR*LANES-1:0]  wr_lane,
    input  logic [N_RD-1:0]        rd_en,
    input  logic [N_RD*ADDR_W-1:0] rd_addr,
    output logic [N_RD*DATA_W-1:0] rd_data
);

    logic [N_WR*ADDR_W-1:0] pnd_addr_all;
    logic [N_WR*DATA_W-1:0] pnd_data_all;
    logic [N_WR*LANES-1:0]  pnd_lane_all;
    logic [N_RD*DATA_W-1:0] stored_all;

    for (genvar p = 0; p < N_WR; p++) begin : g_wr
        rfram_wr_stage #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
        ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_addr (wr_addr[p*ADDR_W +: ADDR_W]),
            .req_data (wr_data[p*DATA_W +: DATA_W]),
            .req_lane (wr_lane[p*LANES +: LANES]),
            .pnd_addr (pnd_addr_all[p*ADDR_W +: ADDR_W]),
            .pnd_data (pnd_data_all[p*DATA_W +: DATA_W]),
            .pnd_lane (pnd_lane_all[p*LANES +: LANES])
        );
    end

    rfram_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
        .N_WR(N_WR), .N_RD(N_RD)
    ) u_store (
        .clk      (clk),
        .cm_addr  (pnd_addr_all),
        .cm_data  (pnd_data_all),
        .cm_lane  (pnd_lane_all),
        .tap_addr (rd_addr),
        .tap_word (stored_all)
    );

    for (genvar r = 0; r < N_RD; r++) begin : g_rd
        rfram_rd_port #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .N_WR(N_WR)
        ) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (rd_en[r]),
            .addr     (rd_addr[r*ADDR_W +: ADDR_W]),
            .stored   (stored_all[r*DATA_W +: DATA_W]),
            .pnd_addr (pnd_addr_all),
            .pnd_data (pnd_data_all),
            .pnd_lane (pnd_lane_all),
            .data     (rd_data[r*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/rfram_chk.sv
module rfram_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int N_WR   = 2,
    parameter int N_RD   = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_RD-1:0]        rd_en,
    input logic [N_RD*ADDR_W-1:0] rd_addr,
    input logic [N_RD*DATA_W-1:0] rd_data,
    input logic [N_WR*ADDR_W-1:0] pnd_addr,
    input logic [N_WR*DATA_W-1:0] pnd_data,
    input logic [N_WR*LANES-1:0]  pnd_lane
);

    localparam int TOP = N_WR - 1;

    logic was_rst;
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R3: a reset edge leaves no pending lane and zeroed outputs
    always_ff @(posedge clk) begin
        if (was_rst) begin
            a_r3_pend_clear: assert (pnd_lane == '0);
            a_r3_out_clear:  assert (rd_data == '0);
        end
    end

    for (genvar r = 0; r < N_RD; r++) begin : g_rp
        // R7: disabled read port keeps its output
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en[r] |=> $stable(rd_data[r*DATA_W +: DATA_W]));

        // R5 / R6: a full-lane pending write on the top-ranked port is
        // what a matching read returns on the next edge
        a_r6_top_fwd: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en[r] && pnd_lane[TOP*LANES +: LANES] == '1 &&
             pnd_addr[TOP*ADDR_W +: ADDR_W] == rd_addr[r*ADDR_W +: ADDR_W])
            |=> rd_data[r*DATA_W +: DATA_W] == $past(pnd_data[TOP*DATA_W +: DATA_W]));
    end

endmodule

bind rfram_top rfram_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES), .N_WR(N_WR), .N_RD(N_RD)
) u_rfram_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pnd_addr (pnd_addr_all),
    .pnd_data (pnd_data_all),
    .pnd_lane (pnd_lane_all)
);

// File: tb/test_rfram_top.sv
module test_rfram_top;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;
    localparam int LANES  = 2;
    localparam int N_WR   = 2;
    localparam int N_RD   = 2;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LW     = DATA_W / LANES;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [N_WR*ADDR_W-1:0] wr_addr;
    logic [N_WR*DATA_W-1:0] wr_data;
    logic [N_WR*LANES-1:0]  wr_lane;
    logic [N_RD-1:0]        rd_en;
    logic [N_RD*ADDR_W-1:0] rd_addr;
    logic [N_RD*DATA_W-1:0] rd_data;

    always #10 clk = ~clk;

    rfram_top #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES), .N_WR(N_WR), .N_RD(N_RD)
    ) i_rfram_top (
        .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_lane(wr_lane), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int    checks = 0;
    int    errors = 0;
    bit    chk_on = 1'b0;
    bit    done   = 1'b0;
    string tag    = "R3";

    // Behavioural read-first model: reads see memory before this edge's writes.
    logic [DATA_W-1:0] mem_m [DEPTH];
    logic [DATA_W-1:0] exp_q [N_RD];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N_RD; r++) exp_q[r] = '0;
        end else begin
            for (int r = 0; r < N_RD; r++)
                if (rd_en[r]) exp_q[r] = mem_m[rd_addr[r*ADDR_W +: ADDR_W]];
            for (int p = 0; p < N_WR; p++)
                for (int l = 0; l < LANES; l++)
                    if (wr_lane[p*LANES + l])
                        mem_m[wr_addr[p*ADDR_W +: ADDR_W]][l*LW +: LW] =
                            wr_data[p*DATA_W + l*LW +: LW];
        end
    end

    task automatic check(input string t, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    // Compare every read port each cycle, away from the active edge.
    always @(negedge clk) begin
        if (chk_on)
            for (int r = 0; r < N_RD; r++)
                check(tag, rd_data[r*DATA_W +: DATA_W], exp_q[r]);
    end

    task automatic set_wr(input int p, input int a, input int d, input int ln);
        wr_addr[p*ADDR_W +: ADDR_W] = ADDR_W'(a);
        wr_data[p*DATA_W +: DATA_W] = DATA_W'(d);
        wr_lane[p*LANES +: LANES]   = LANES'(ln);
    endtask

    task automatic set_rd(input int r, input bit en, input int a);
        rd_en[r]                    = en;
        rd_addr[r*ADDR_W +: ADDR_W] = ADDR_W'(a);
    endtask

    task automatic idle();
        for (int p = 0; p < N_WR; p++) set_wr(p, 0, 0, 0);
        for (int r = 0; r < N_RD; r++) set_rd(r, 1'b0, 0);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        idle();
        // R3: writes during reset must be dropped
        set_wr(1, 0, 'hDEAD, 3);
        step();
        chk_on = 1'b1;
        step(); step();
        rst_n = 1'b1;
        idle();

        // R7: fill memory with reads disabled; outputs must stay at zero
        tag = "R7";
        for (int a = 0; a < DEPTH; a++) begin
            set_wr(0, a, (a * 'h1111) ^ 'h0F0F, 3);
            step();
        end
        idle();
        step();

        // R8: both ports read every word, in opposite orders
        tag = "R8";
        for (int a = 0; a < DEPTH; a++) begin
            set_rd(0, 1'b1, a);
            set_rd(1, 1'b1, DEPTH - 1 - a);
            step();
        end
        idle();
        step();

        // R2: same-edge write and read of word 3 returns the old word
        tag = "R2";
        set_wr(0, 3, 'hA5A5, 3);
        set_rd(0, 1'b1, 3);
        set_rd(1, 1'b1, 3);
        step();
        // R5: next edge sees the new word through the bypass
        tag = "R5";
        set_wr(0, 0, 0, 0);
        step();
        idle();
        step();

        // R4: lane 0 only on word 5, then read twice
        tag = "R4";
        set_wr(1, 5, 'h1234, 1);
        step();
        set_wr(1, 0, 0, 0);
        set_rd(0, 1'b1, 5);
        step();
        set_rd(1, 1'b1, 5);
        step();
        set_wr(0, 5, 'hBEEF, 2);
        step();
        set_wr(0, 0, 0, 0);
        step();
        idle();
        step();

        // R6: overlapping lanes on word 6, then disjoint lanes on word 2
        tag = "R6";
        set_wr(0, 6, 'h1111, 3);
        set_wr(1, 6, 'h2222, 3);
        step();
        set_wr(0, 2, 'h33CC, 1);
        set_wr(1, 2, 'h44DD, 2);
        set_rd(0, 1'b1, 6);
        step();
        set_wr(0, 0, 0, 0);
        set_wr(1, 0, 0, 0);
        set_rd(0, 1'b1, 2);
        set_rd(1, 1'b1, 6);
        step();
        set_rd(0, 1'b1, 6);
        set_rd(1, 1'b1, 2);
        step();
        set_wr(0, 1, 'h5555, 2);
        set_wr(1, 1, 'h6666, 3);
        step();
        set_wr(0, 0, 0, 0);
        set_wr(1, 0, 0, 0);
        set_rd(0, 1'b1, 1);
        step();
        idle();
        step();

        // R9: lanes all low must change nothing
        tag = "R9";
        set_wr(0, 4, 'hFFFF, 0);
        set_wr(1, 4, 'h0000, 0);
        set_rd(0, 1'b1, 4);
        step();
        set_rd(1, 1'b1, 4);
        step();
        idle();
        step();

        // R1: random traffic with dense collisions
        tag = "R1";
        for (int c = 0; c < 3000; c++) begin
            for (int p = 0; p < N_WR; p++)
                set_wr(p, int'($urandom % DEPTH), int'($urandom), int'($urandom % 4));
            for (int r = 0; r < N_RD; r++)
                set_rd(r, ($urandom % 4) != 0, int'($urandom % DEPTH));
            step();
        end
        idle();
        step();

        // R3: reset mid-run with writes driven; they must not land
        tag = "R3";
        rst_n = 1'b0;
        set_wr(0, 0, 'hDEAD, 3);
        set_wr(1, 7, 'hBEEF, 3);
        step(); step();
        rst_n = 1'b1;
        idle();
        step();
        set_rd(0, 1'b1, 0);
        set_rd(1, 1'b1, 7);
        step();
        idle();
        step(); step();

        chk_on = 1'b0;
        done   = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule